// File: doc/BRIEF.md
# MSI Capture Ring-Buffer Writer

This block receives message-signalled interrupts. Each message carries a 32-bit interrupt number. The block stores every accepted message as a 16-byte record in a circular queue that lives in system memory. Software first programs a 64-bit base address and a power-of-two queue size. It then consumes records by advancing a read offset. The block advances a write offset once each record has landed in memory, and it holds a level interrupt towards the host while work is pending or while the queue is full.

A small register port gives software access to the control word, the base address halves and both offsets. A single-outstanding memory write master presents one record at a time as an address plus a 128-bit record, using a valid/ready handshake. Flow control is decided in the control word:
- Capture can be enabled or disabled.
- Interrupt reporting can be enabled or disabled.
- Full reporting can be enabled or disabled.
- Stop-on-full can be enabled or disabled.

A two-state machine sequences the work:
- `ST_IDLE` accepts messages.
- `ST_WRITE` holds a record on the memory port until it is taken.
- Transition `take_record` (`ST_IDLE` to `ST_WRITE`) fires when a message is accepted while capture is enabled and the message is not dropped for being full.
- Transition `record_landed` (`ST_WRITE` to `ST_IDLE`) fires on the memory handshake.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset:
  - every register reads zero;
  - `irq` and `mem_valid` are low;
  - `msi_ready` is high.
- R2: Register selects:
  - 0 is control;
  - 3 is the base high word;
  - 4 is the base low word;
  - 5 is the read offset;
  - 6 is the write offset, which is read-only, so writes to it have no effect.
- R2 (control bits): bit 0 is capture enable, bit 1 is full-report enable, bit 3 is interrupt enable, bit 4 is stop-on-full, and bits 9:8 are the size code. Bit 16 is a read-only sticky drop flag. All other bits read zero.
- R3: Each record is written at base + write offset. Bits 31:0 of `mem_data` (bytes 0 to 3, little-endian) hold the interrupt number, and bits 127:32 are zero.
- R4: Only one memory write is outstanding at a time:
  - `msi_ready` is low while a record is pending;
  - the record is held stable until `mem_ready`;
  - the write offset advances by 16 only in the cycle of the handshake.
- R5: With size code c the queue spans 2^(15+c) bytes. The write offset wraps to zero after 2^(15+c) − 16.
- R6: With capture disabled, an accepted message produces no memory write and leaves the write offset unchanged.
- R7: The queue is full when (write offset + 16) mod size equals the read offset. With stop-on-full set, a message arriving while full is dropped and sets the sticky flag. Any control write clears that flag.
- R8: With stop-on-full clear, a message arriving while full is still written.
- R9: `irq` = (interrupt enable AND write offset ≠ read offset) OR (full-report enable AND full).
- R10: A value written to the read offset is masked to 16-byte alignment and to the configured size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| msi_valid | input | 1 | Incoming message valid |
| msi_num | input | 32 | Incoming interrupt number |
| msi_ready | output | 1 | Block can take a message |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the record |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| irq | output | 1 | Level interrupt to host |

## Verification
The assertions assume the following about the inputs:
- `mem_ready` may stall for any number of cycles but eventually responds.
- `msi_valid` may be raised in any cycle, including while a record is pending.
- Software does not change the size code while records are outstanding.

The bench drives every input at the falling edge and keeps each message valid for exactly one cycle. It changes the size only when no record is pending. It also deliberately raises a message while a write is stalled, to exercise the single-outstanding rule.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
    typedef enum logic {ST_IDLE, ST_WRITE} wr_state_e;

    typedef struct packed {
        logic [1:0] size;
        logic       stop;
        logic       irq_en;
        logic       full_en;
        logic       cap_en;
    } ctrl_t;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_BASE_HI = 3'd3;
    localparam logic [2:0] SEL_BASE_LO = 3'd4;
    localparam logic [2:0] SEL_RD_OFF  = 3'd5;
    localparam logic [2:0] SEL_WR_OFF  = 3'd6;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int OFF_W     = 18,
    parameter int REC_SHIFT = 4,
    parameter int MIN_SHIFT = 15,
    parameter int REG_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             adv,
    input  logic             drop,
    output ctrl_t            ctrl_q,
    output logic [2*REG_W-1:0] base_q,
    output logic [OFF_W-1:0] woff_q,
    output logic [OFF_W-1:0] roff_q,
    output logic             full
);
    localparam int REC_BYTES = 1 << REC_SHIFT;

    logic             sticky_q;
    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] woff_next;

    always_comb begin
        for (int b = 0; b < OFF_W; b++)
            mask[b] = (b >= REC_SHIFT) && (b < MIN_SHIFT + int'(ctrl_q.size));
    end

    assign woff_next = (woff_q + OFF_W'(REC_BYTES)) & mask;
    assign full      = (woff_next == roff_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            base_q   <= '0;
            woff_q   <= '0;
            roff_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            if (adv) woff_q <= woff_next;
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_CTRL: begin
                        ctrl_q.cap_en  <= reg_wdata[0];
                        ctrl_q.full_en <= reg_wdata[1];
                        ctrl_q.irq_en  <= reg_wdata[3];
                        ctrl_q.stop    <= reg_wdata[4];
                        ctrl_q.size    <= reg_wdata[9:8];
                    end
                    SEL_BASE_HI: base_q[2*REG_W-1:REG_W] <= reg_wdata;
                    SEL_BASE_LO: base_q[REG_W-1:0]       <= reg_wdata;
                    SEL_RD_OFF:  roff_q <= reg_wdata[OFF_W-1:0] & mask;
                    default: ;
                endcase
            end
            if (drop)
                sticky_q <= 1'b1;
            else if (reg_wr && reg_sel == SEL_CTRL)
                sticky_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:    reg_rdata = {15'd0, sticky_q, 6'd0, ctrl_q.size, 3'd0,
                                      ctrl_q.stop, ctrl_q.irq_en, 1'b0,
                                      ctrl_q.full_en, ctrl_q.cap_en};
            SEL_BASE_HI: reg_rdata = base_q[2*REG_W-1:REG_W];
            SEL_BASE_LO: reg_rdata = base_q[REG_W-1:0];
            SEL_RD_OFF:  reg_rdata = {(REG_W-OFF_W)'(0), roff_q};
            SEL_WR_OFF:  reg_rdata = {(REG_W-OFF_W)'(0), woff_q};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_ring_fsm.sv
module msi_ring_fsm
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REC_W  = 128,
    parameter int NUM_W  = 32,
    parameter int OFF_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [NUM_W-1:0]  msi_num,
    output logic              msi_ready,
    input  logic              cap_en,
    input  logic              stop,
    input  logic              full,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  woff,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data,
    output logic              adv,
    output logic              drop
);
    wr_state_e          state_q, state_d;
    logic [NUM_W-1:0]   num_q;
    logic               take, take_record;

    assign take        = msi_valid && (state_q == ST_IDLE);
    assign take_record = take && cap_en && !(stop && full);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_record) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready)   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            num_q    <= '0;
            mem_addr <= '0;
        end else begin
            state_q <= state_d;
            if (take_record) begin
                num_q    <= msi_num;
                mem_addr <= base + ADDR_W'(woff);
            end
        end
    end

    always_comb begin
        msi_ready = 1'b0;
        mem_valid = 1'b0;
        adv       = 1'b0;
        drop      = take && cap_en && stop && full;
        unique case (state_q)
            ST_IDLE:  msi_ready = 1'b1;
            ST_WRITE: begin
                mem_valid = 1'b1;
                adv       = mem_ready;
            end
            default: ;
        endcase
    end

    assign mem_data = {(REC_W-NUM_W)'(0), num_q};
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int OFF_W     = 18,
    parameter int REC_SHIFT = 4,
    parameter int MIN_SHIFT = 15,
    parameter int REG_W     = 32,
    parameter int NUM_W     = 32,
    parameter int REC_W     = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 msi_valid,
    input  logic [NUM_W-1:0]     msi_num,
    output logic                 msi_ready,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [2*REG_W-1:0]   mem_addr,
    output logic [REC_W-1:0]     mem_data,
    output logic                 irq
);
    localparam int ADDR_W = 2 * REG_W;

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  woff_q, roff_q;
    logic              full, adv, drop;

    msi_ring_regs #(
        .OFF_W(OFF_W), .REC_SHIFT(REC_SHIFT), .MIN_SHIFT(MIN_SHIFT), .REG_W(REG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv), .drop(drop),
        .ctrl_q(ctrl_q), .base_q(base_q), .woff_q(woff_q), .roff_q(roff_q),
        .full(full)
    );

    msi_ring_fsm #(
        .ADDR_W(ADDR_W), .REC_W(REC_W), .NUM_W(NUM_W), .OFF_W(OFF_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_num(msi_num),
        .msi_ready(msi_ready), .cap_en(ctrl_q.cap_en), .stop(ctrl_q.stop),
        .full(full), .base(base_q), .woff(woff_q), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .adv(adv), .drop(drop)
    );

    assign irq = (ctrl_q.irq_en && (woff_q != roff_q)) || (ctrl_q.full_en && full);
endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk #(
    parameter int OFF_W = 18,
    parameter int NUM_W = 32,
    parameter int REC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msi_valid,
    input logic             msi_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [63:0]      mem_addr,
    input logic [REC_W-1:0] mem_data,
    input logic             irq,
    input logic             cap_en,
    input logic             irq_en,
    input logic             full_en,
    input logic [OFF_W-1:0] woff
);
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !msi_ready);
    // R4
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid);
    // R4
    woff_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(woff) |-> $past(mem_valid && mem_ready));
    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_data[REC_W-1:NUM_W] == '0);
    // R6
    no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && msi_ready && !cap_en |=> !mem_valid);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en && !full_en |-> !irq);
endmodule

bind msi_ring_writer msi_ring_chk #(.OFF_W(OFF_W), .NUM_W(NUM_W), .REC_W(REC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq), .cap_en(ctrl_q.cap_en),
    .irq_en(ctrl_q.irq_en), .full_en(ctrl_q.full_en), .woff(woff_q)
);

// File: tb/msi_ring_writer_test.sv
module msi_ring_writer_test;
    localparam int CLK_P = 10;
    localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;
    // {interrupt number, expected write offset after the record}
    localparam logic [63:0] VEC [4] = '{
        {32'h0000_0021, 32'h10}, {32'hDEAD_BEEF, 32'h20},
        {32'h0000_0000, 32'h30}, {32'hFFFF_FFFF, 32'h40}
    };

    logic         clk = 0, rst_n = 0, reg_wr = 0, msi_valid = 0, mem_ready = 0;
    logic [2:0]   reg_sel = 0;
    logic [31:0]  reg_wdata = 0, reg_rdata, msi_num = 0;
    logic         msi_ready, mem_valid, irq;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    int errors = 0, checks = 0;
    logic [31:0]  woff_m;

    msi_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_num(msi_num), .msi_ready(msi_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        reg_sel = sel; #1; d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] n);
        msi_valid = 1; msi_num = n;
        @(posedge clk); @(negedge clk);
        msi_valid = 0;
    endtask

    task automatic land;
        mem_ready = 1;
        @(posedge clk); @(negedge clk);
        mem_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int s = 0; s < 7; s++) begin
            rd(3'(s), v); chk("R1 reg", v, 0);
        end
        chk("R1 irq", irq, 0); chk("R1 mem_valid", mem_valid, 0); chk("R1 msi_ready", msi_ready, 1);

        // R2 configuration
        wr(3'd3, BASE[63:32]); wr(3'd4, BASE[31:0]); wr(3'd0, 32'hFFFF_F109 & 32'h0000_0109);
        rd(3'd3, v); chk("R2 base hi", v, BASE[63:32]);
        rd(3'd4, v); chk("R2 base lo", v, BASE[31:0]);
        rd(3'd0, v); chk("R2 ctrl", v, 32'h109);
        wr(3'd6, 32'h100); rd(3'd6, v); chk("R2 woff read-only", v, 0);

        // R3 table walk
        woff_m = 0;
        for (int i = 0; i < 4; i++) begin
            send(VEC[i][63:32]);
            chk("R3 addr", mem_addr, BASE + 64'(woff_m));
            chk("R3 data", mem_data, {96'd0, VEC[i][63:32]});
            chk("R4 busy", msi_ready, 0);
            land;
            woff_m = VEC[i][31:0];
            rd(3'd6, v); chk("R4 woff step", v, VEC[i][31:0]);
            chk("R9 irq pending", irq, 1);
        end

        // R4 back-pressure, second message offered while busy
        send(32'h0000_ABCD);
        msi_valid = 1; msi_num = 32'h5555;
        repeat (3) @(negedge clk);
        msi_valid = 0;
        rd(3'd6, v); chk("R4 woff held", v, 32'h40);
        chk("R4 still valid", mem_valid, 1);
        chk("R4 data kept", mem_data, {96'd0, 32'h0000_ABCD});
        land;
        chk("R4 single", mem_valid, 0);
        rd(3'd6, v); chk("R4 woff after", v, 32'h50);

        // R9 consumer catches up
        wr(3'd5, 32'h50); chk("R9 irq clear", irq, 0);
        // R10 masking
        wr(3'd5, 32'h1234_5678); rd(3'd5, v); chk("R10 mask 64K", v, 32'h5670);
        wr(3'd0, 32'h309); wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R10 mask 256K", v, 32'h3FFF0);
        wr(3'd5, 32'h50);

        // R5 and R7 wrap and fill a 32 KB queue with stop-on-full
        wr(3'd0, 32'h13);
        woff_m = 32'h50;
        for (int k = 0; k < 2047; k++) begin
            send(32'(k));
            if (woff_m == 32'h7FF0) chk("R5 last slot", mem_addr, BASE + 64'h7FF0);
            if (woff_m == 32'h0)    chk("R5 wrap to zero", mem_addr, BASE);
            land;
            woff_m = (woff_m + 32'h10) & 32'h7FF0;
        end
        rd(3'd6, v); chk("R5 woff", v, 32'h40);
        chk("R7 full irq", irq, 1);
        send(32'h77);
        chk("R7 dropped", mem_valid, 0);
        rd(3'd0, v); chk("R7 sticky", v, 32'h0001_0013);
        rd(3'd6, v); chk("R7 woff kept", v, 32'h40);
        wr(3'd0, 32'h03);
        rd(3'd0, v); chk("R7 sticky clear", v, 32'h03);

        // R8 write through when full and stop-on-full clear
        send(32'h88);
        chk("R8 written", mem_valid, 1);
        chk("R8 addr", mem_addr, BASE + 64'h40);
        land;
        rd(3'd6, v); chk("R8 woff", v, 32'h50);
        chk("R9 not full", irq, 0);

        // R6 capture disabled
        wr(3'd0, 32'h08);
        send(32'h99);
        chk("R6 no write", mem_valid, 0);
        rd(3'd6, v); chk("R6 woff", v, 32'h50);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule